// File: doc/BRIEF.md
# Bit-Banged Management Interface Target

This block is the target side of a two-wire station management link. Software does not drive a real management clock pin. It writes a small control word that holds a clock bit, a data-out bit and an output-enable bit. The block treats every 0-to-1 change of the written clock bit as one clock edge on the serial line. On each such edge it shifts in one bit and locks onto a run of thirty-two ones. It then decodes the sixteen-bit command header that follows. For a read, it returns the addressed sixteen-bit register, one bit per edge, on a data-in bit that software can only read.

The target holds a bank of 32 sixteen-bit PHY registers. Two of them hold identifier values and the others read as zero. Write commands are decoded and run through their data phase in full, but the data is thrown away. The PHY address field is decoded but does not select anything, so the block answers any PHY address.

Top module: `mdio_bitbang_target`

## Requirements
- R1: The control word has four bits: data-out at bit 0, data-in at bit 1, output-enable at bit 2 and clock at bit 3. After a write, bits 0, 2 and 3 read back the written values from the next cycle. All four bits are 0 after reset.
- R2: Software cannot write the data-in bit. A control write with no clock rising edge leaves data-in unchanged, whatever value is written at bit 1.
- R3: A bit is taken only when the clock bit goes from 0 to 1 compared with its previously written value. Writing the clock bit as 1 again is not a new edge. The sampled bit is data-out AND output-enable, so ones driven with output-enable low are taken as zeros.
- R4: When the last 32 sampled bits are all ones, the bit counter reloads to 32. It then decrements by one on every edge.
- R5: Sixteen edges after the last preamble one, the header is decoded from the 16 most recent bits. The fields are: start at bits 15:14, opcode at 13:12, PHY address at 11:7, register address at 6:2, turnaround at 1:0.
- R6: A read needs start 01, opcode 10 and turnaround bit 0 equal to 0. Over the next 16 edges, the addressed register appears on data-in, most significant bit first, one bit per edge.
- R7: A write needs start 01, opcode 01 and turnaround exactly 10. Its 16 data bits are consumed and discarded, so a later read of that register returns the unchanged value.
- R8: Any other header, including a read whose turnaround bit 0 is 1, returns the block to idle and leaves data-in unchanged.
- R9: PHY register 2 reads 0x0022, register 3 reads 0x161A, and every other register reads 0x0000.
- R10: The PHY address field has no effect: any PHY address returns the same data for the same register.
- R11: After the last data bit of a command the block is idle. Further edges without a new preamble do not change data-in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 4 | Control word write data |
| ctl_rdata | output | 4 | Control word read data, data-in at bit 1 |

## Verification
The bench builds the block with its default parameters: 32 registers and identifiers at indices 2 and 3. With these values a full sweep is small. It reads every register index, each time with a different PHY address, so the identifier decode and the address-independence rule are both covered. On top of that sweep, the bench tests:
- a write to an identifier register followed by a read-back of that register;
- a read header with an invalid turnaround;
- a preamble driven with output-enable low;
- frames in which each clock-high write is repeated;
- writes made in the middle of a read that try to overwrite data-in.

// File: rtl/mdio_bitbang_target.sv
module mdio_bitbang_target #(
  parameter int          REG_COUNT = 32,
  parameter int          DATA_W    = 16,
  parameter int          ID_A_IDX  = 2,
  parameter int          ID_B_IDX  = 3,
  parameter logic [15:0] ID_A_VAL  = 16'h0022,
  parameter logic [15:0] ID_B_VAL  = 16'h161A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [3:0] ctl_wdata,
  output logic [3:0] ctl_rdata
);
  localparam int ADDR_W = $clog2(REG_COUNT);
  localparam int SYNC_W = 2 * DATA_W;
  localparam logic [1:0] S_IDLE = 2'd0, S_RD = 2'd1, S_WR = 2'd2;

  logic [3:0]        ctl_q;
  logic [SYNC_W-1:0] sh;
  logic signed [6:0] cnt;
  logic [1:0]        st;
  logic [DATA_W-1:0] dout;

  logic              rise, sbit, dec, shift_out, done;
  logic [SYNC_W-1:0] sh_n;
  logic signed [6:0] cnt_a;
  logic [1:0]        st_a;
  logic [DATA_W-1:0] dout_a, bank_q;
  logic [ADDR_W-1:0] freg;
  logic              unused_bits;

  assign rise  = ctl_we & ~ctl_q[3] & ctl_wdata[3];
  assign sbit  = ctl_wdata[0] & ctl_wdata[2];
  assign sh_n  = {sh[SYNC_W-2:0], sbit};
  assign cnt_a = (&sh_n) ? 7'sd32 : cnt;
  assign dec   = (cnt_a == 7'sd16);
  assign freg  = sh_n[2 +: ADDR_W];
  assign unused_bits = ^{ctl_wdata[1], sh_n[11:7]};

  always_comb begin
    bank_q = '0;
    if (int'(freg) == ID_A_IDX) bank_q = ID_A_VAL;
    if (int'(freg) == ID_B_IDX) bank_q = ID_B_VAL;
  end

  always_comb begin
    st_a = st;
    if (dec) begin
      if (sh_n[15:12] == 4'b0101 && sh_n[1:0] == 2'b10)   st_a = S_WR;
      else if (sh_n[15:12] == 4'b0110 && !sh_n[0])        st_a = S_RD;
      else                                                st_a = S_IDLE;
    end
  end

  assign dout_a    = (dec && st_a == S_RD) ? bank_q : dout;
  assign shift_out = rise && (cnt_a < 7'sd16) && (st_a == S_RD);
  assign done      = (cnt_a == 7'sd0) && (st_a != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      sh    <= '0;
      cnt   <= '0;
      st    <= S_IDLE;
      dout  <= '0;
    end else begin
      if (ctl_we)
        ctl_q <= {ctl_wdata[3], ctl_wdata[2],
                  shift_out ? dout_a[DATA_W-1] : ctl_q[1], ctl_wdata[0]};
      if (rise) begin
        sh   <= sh_n;
        cnt  <= (cnt_a == -7'sd1) ? cnt_a : cnt_a - 7'sd1;
        st   <= done ? S_IDLE : st_a;
        dout <= shift_out ? {dout_a[DATA_W-2:0], 1'b0} : dout_a;
      end
    end
  end

  assign ctl_rdata = ctl_q;
endmodule

module mdio_bitbang_target_chk (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_we,
  input logic [3:0]        ctl_wdata,
  input logic [3:0]        ctl_rdata,
  input logic [1:0]        st,
  input logic signed [6:0] cnt
);
  logic edge_w;
  assign edge_w = ctl_we && ctl_wdata[3] && !ctl_rdata[3];

  p_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (ctl_rdata[3] == $past(ctl_wdata[3]) && ctl_rdata[2] == $past(ctl_wdata[2])
                && ctl_rdata[0] == $past(ctl_wdata[0])));

  p_di_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !edge_w) |=> $stable(ctl_rdata[1]));

  p_no_write_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(ctl_rdata));

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    edge_w |=> (cnt == 7'sd31 || cnt == -7'sd1 || cnt == $past(cnt) - 7'sd1));

  p_di_only_reading_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 2'd1) |=> $stable(ctl_rdata[1]));
endmodule

bind mdio_bitbang_target mdio_bitbang_target_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .ctl_rdata(ctl_rdata), .st(st), .cnt(cnt)
);

// File: tb/mdio_bitbang_target_tb.sv
module mdio_bitbang_target_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       ctl_we = 0;
  logic [3:0] ctl_wdata = '0;
  logic [3:0] ctl_rdata;
  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  mdio_bitbang_target dut_i (.clk(clk), .rst_n(rst_n), .ctl_we(ctl_we),
                             .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_reg(input int ra);
    return (ra == 2) ? 16'h0022 : (ra == 3) ? 16'h161A : 16'h0000;
  endfunction

  task automatic put(input logic [3:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic bit_edge(input logic b, input logic oe, input bit dbl);
    put({1'b0, oe, 1'b0, b});
    put({1'b1, oe, 1'b0, b});
    if (dbl) put({1'b1, oe, 1'b1, ~b});
  endtask

  task automatic frame(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra,
                       input logic [1:0] ta, input logic ta_oe, input logic [15:0] wd,
                       input logic pre_oe, input bit dbl, output logic [15:0] got);
    logic [15:0] hdr;
    hdr = {2'b01, op, pa, ra, 2'b00};
    got = '0;
    for (int i = 0; i < 32; i++) bit_edge(1'b1, pre_oe, dbl);
    for (int i = 15; i >= 2; i--) bit_edge(hdr[i], 1'b1, dbl);
    bit_edge(ta[1], ta_oe, dbl);
    bit_edge(ta[0], ta_oe, dbl);
    for (int i = 15; i >= 0; i--) begin
      if (op == 2'b01) bit_edge(wd[i], 1'b1, dbl);
      else begin
        bit_edge(1'b0, 1'b0, dbl);
        got[i] = ctl_rdata[1];
      end
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] got;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset", ctl_rdata, 0);
    put(4'b1101);
    check("R1 readback", ctl_rdata, 4'b1101);
    put(4'b0010);
    check("R2 di not writable", ctl_rdata, 4'b0000);

    // R9 R10 R6: sweep all register indices, PHY address varies
    for (int ra = 0; ra < 32; ra++) begin
      frame(2'b10, 5'(31 - ra), 5'(ra), 2'b00, 1'b0, 16'h0, 1'b1, 1'b0, got);
      check($sformatf("R9 R10 R6 read reg %0d", ra), got, exp_reg(ra));
    end

    // R7: write discarded
    frame(2'b01, 5'd1, 5'd3, 2'b10, 1'b1, 16'hA5A5, 1'b1, 1'b0, got);
    frame(2'b10, 5'd1, 5'd3, 2'b00, 1'b0, 16'h0, 1'b1, 1'b0, got);
    check("R7 write discarded", got, 16'h161A);

    // R8: read with turnaround bit0 = 1 is rejected
    frame(2'b10, 5'd0, 5'd2, 2'b11, 1'b1, 16'h0, 1'b1, 1'b0, got);
    check("R8 bad turnaround", got, 0);

    // R3: preamble with output enable low never syncs
    frame(2'b10, 5'd0, 5'd3, 2'b00, 1'b0, 16'h0, 1'b0, 1'b0, got);
    check("R3 oe low preamble", got, 0);

    // R3: repeated clock-high writes are not extra edges
    frame(2'b10, 5'd7, 5'd3, 2'b00, 1'b0, 16'h0, 1'b1, 1'b1, got);
    check("R3 no double sample", got, 16'h161A);

    // R2: write attempts mid-read do not disturb data-in (reg3 MSBs 0001)
    for (int i = 0; i < 32; i++) bit_edge(1'b1, 1'b1, 1'b0);
    begin
      logic [15:0] hdr;
      hdr = {2'b01, 2'b10, 5'd4, 5'd3, 2'b00};
      for (int i = 15; i >= 2; i--) bit_edge(hdr[i], 1'b1, 1'b0);
    end
    bit_edge(1'b0, 1'b0, 1'b0);
    bit_edge(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) bit_edge(1'b0, 1'b0, 1'b0);
    check("R6 mid read bit", ctl_rdata[1], 1);
    put(4'b1101);
    check("R2 hold with clk high", ctl_rdata[1], 1);
    put(4'b0000);
    check("R2 hold with clk low", ctl_rdata[1], 1);
    for (int i = 0; i < 12; i++) bit_edge(1'b0, 1'b0, 1'b0);

    // R11: idle after a read completes; ending a read of reg 2 leaves 0, then edges
    frame(2'b10, 5'd0, 5'd2, 2'b00, 1'b0, 16'h0, 1'b1, 1'b0, got);
    check("R11 last read", got, 16'h0022);
    begin
      int changed = 0;
      for (int i = 0; i < 40; i++) begin
        bit_edge(1'b0, 1'b1, 1'b0);
        if (ctl_rdata[1] !== 1'b0) changed++;
      end
      check("R11 idle after read", changed, 0);
    end

    // R4: resync mid-frame: a fresh preamble restarts decoding correctly
    for (int i = 0; i < 5; i++) bit_edge(1'b0, 1'b1, 1'b0);
    frame(2'b10, 5'd9, 5'd2, 2'b00, 1'b0, 16'h0, 1'b1, 1'b0, got);
    check("R4 R5 resync read", got, 16'h0022);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule